// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes received Ethernet frames as a byte stream and stores them in a circular buffer held in an external word-wide memory. Each stored frame occupies a 4-byte header slot followed by its bytes. The header is written last, once the frame has ended, and carries the byte count and the upstream status word. The next frame starts on the following 4-byte boundary, and data that passes the end of the ring continues at offset 0.

Software consumes frames and reports progress by writing a read-pointer register. By convention it writes the consumed offset minus 16, and the block adds the 16 back. The block compares the pointer with its own write pointer to produce a ring-empty flag and to find the free space. A frame that would not fit in the free space is discarded whole and counted. Completion and loss events set sticky bits in an interrupt status word, and software clears a bit by writing a one to it.

Top module: `rxring_writer`

## Requirements
- R1: The ring size in bytes is RING_BASE shifted left by `cfg_size_idx`. Index values 0, 1 and 2 give 1x, 2x and 4x; the value 3 is handled as 2.
- R2: A committed frame's header word sits at the frame's start offset and is little-endian. Bits 15:0 hold `in_status` as sampled with the last byte, and bits 31:16 hold the number of bytes delivered, FCS included.
- R3: Byte k of a frame is stored at byte offset (start + 4 + k) mod size. Byte offset o maps to word o/4, byte lane o mod 4 (lane 0 = `mem_wdata[7:0]`, enable `mem_be[0]`).
- R4: Frame data that runs past the last byte of the ring continues at offset 0.
- R5: After a committed frame of n bytes, the next frame starts at start + 4 + n rounded up to a multiple of 4, modulo the size.
- R6: A write to the read-pointer register sets the effective read offset to (written value + 16) mod size.
- R7: `rx_empty` is 1 when the effective read offset equals the write offset. It follows a change of either pointer within two cycles and is 1 after reset.
- R8: `irq_status` bit 0 is set for each committed frame. Writing 1 to a bit of `isr_clr_data` with `isr_clr_we` clears that bit, and a 0 leaves it unchanged.
- R9: Free space is (read - write) mod size, or the full size when the two are equal. A frame whose 4 + round-up-4(n) is not below the free space is not committed: no header is written, the write pointer stays, already unread frames stay intact, bit 4 is set and `missed_count` increments.
- R10: A byte that arrives in the cycle in which a committed frame's header is written is lost. Bit 6 is set and `missed_count` increments at once, and the remainder of that frame is discarded.
- R11: After reset, `irq_status` is 0, `missed_count` is 0, `mem_we` is 0 and the write and read offsets are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size_idx | input | 2 | Ring size index |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_status | input | 16 | Receive status, sampled with the last byte |
| rdptr_we | input | 1 | Read-pointer register write |
| rdptr_wdata | input | 16 | Consumed offset minus 16 |
| isr_clr_we | input | 1 | Interrupt status write (write one to clear) |
| isr_clr_data | input | 16 | Bits to clear |
| irq_status | output | 16 | Bit 0 frame stored, bit 4 ring overflow, bit 6 input overrun |
| rx_empty | output | 1 | Ring holds no unread frame |
| missed_count | output | MISS_W | Frames lost to overflow or overrun |
| mem_we | output | 1 | Memory word write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Byte enables |

## Verification
Frames with lengths stepping through every residue modulo 4 are sent into a small ring under each size index. This shows whether padding, partial-word enables and wrap-around are placed correctly, and whether the size index is decoded. The consumption rate is varied: sometimes software catches up, which exercises the biased pointer and the empty flag, and sometimes it falls behind until frames no longer fit, which separates a correct free-space bound from an off-by-one. A back-to-back pair of frames shows whether a byte arriving during the header write is dropped as an overrun rather than merged into the stored data.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int HDR_BYTES = 4;
  localparam int PTR_BIAS  = 16;
  localparam int IRQ_OK    = 0;
  localparam int IRQ_OVF   = 4;
  localparam int IRQ_FOVF  = 6;

  typedef struct packed {
    logic [15:0] count;
    logic [15:0] status;
  } rx_hdr_t;
endpackage

// File: rtl/rxr_rdptr.sv
module rxr_rdptr #(
  parameter int RING_BASE = 8192,
  parameter int PW = $clog2(RING_BASE) + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    size_idx,
  input  logic          rd_we,
  input  logic [15:0]   rd_wdata,
  input  logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] size_mask,
  output logic [PW:0]   free_bytes,
  output logic          empty
);
  logic [1:0]    shift;
  logic [PW:0]   ring_size;
  logic [PW-1:0] rd_eff;
  logic [PW-1:0] gap;
  logic [15:0]   eff16;

  assign shift      = (size_idx == 2'd3) ? 2'd2 : size_idx;
  assign ring_size  = (PW+1)'(RING_BASE) << shift;
  assign size_mask  = ring_size[PW-1:0] - PW'(1);
  assign eff16      = rd_wdata + 16'(rxr_pkg::PTR_BIAS);
  assign gap        = (rd_eff - wr_ptr) & size_mask;
  assign free_bytes = (gap == '0) ? ring_size : {1'b0, gap};

  generate
    if (PW < 16) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^eff16[15:PW];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_eff <= '0;
      empty  <= 1'b1;
    end else begin
      if (rd_we) rd_eff <= eff16[PW-1:0] & size_mask;
      empty <= (rd_eff == wr_ptr);
    end
  end
endmodule

// File: rtl/rxr_status.sv
module rxr_status #(
  parameter int MISS_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_ok,
  input  logic              set_ovf,
  input  logic              set_fovf,
  input  logic              clr_we,
  input  logic [15:0]       clr_data,
  output logic [15:0]       status,
  output logic [MISS_W-1:0] missed
);
  logic [15:0] set_vec;
  logic [15:0] clr_vec;

  always_comb begin
    set_vec = '0;
    set_vec[rxr_pkg::IRQ_OK]   = set_ok;
    set_vec[rxr_pkg::IRQ_OVF]  = set_ovf;
    set_vec[rxr_pkg::IRQ_FOVF] = set_fovf;
    clr_vec = clr_we ? clr_data : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      missed <= '0;
    end else begin
      status <= (status & ~clr_vec) | set_vec;
      if (set_ovf || set_fovf) missed <= missed + MISS_W'(1);
    end
  end

  AST_W1C_OK: assert property (@(posedge clk) disable iff (rst)
    (clr_we && clr_data[rxr_pkg::IRQ_OK] && !set_ok) |=> !status[rxr_pkg::IRQ_OK]); // R8
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (rst)
    (missed != $past(missed)) |-> (missed == $past(missed) + MISS_W'(1))); // R9
endmodule

// File: rtl/rxr_wport.sv
module rxr_wport #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   data,
  input  logic [3:0]    be,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_be    <= '0;
    end else begin
      mem_we <= req;
      if (req) begin
        mem_addr  <= addr;
        mem_wdata <= data;
        mem_be    <= be;
      end
    end
  end
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer #(
  parameter int RING_BASE = 8192,
  parameter int MISS_W    = 16,
  localparam int PW = $clog2(RING_BASE) + 2,
  localparam int AW = PW - 2,
  localparam int NW = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_size_idx,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [15:0]       in_status,
  input  logic              rdptr_we,
  input  logic [15:0]       rdptr_wdata,
  input  logic              isr_clr_we,
  input  logic [15:0]       isr_clr_data,
  output logic [15:0]       irq_status,
  output logic              rx_empty,
  output logic [MISS_W-1:0] missed_count,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be
);
  import rxr_pkg::*;

  logic [15:0]   cnt;
  logic [16:0]   cnt_n;
  logic [31:0]   acc, word_n;
  logic          drop, lost, hdr_pend;
  rx_hdr_t       hdr_q;
  logic [PW-1:0] need_q, wr_ptr, size_mask, data_off;
  logic [PW:0]   free_bytes;
  logic [NW-1:0] need_n;
  logic          ovf_n, take, req;
  logic [1:0]    lane;
  logic [4:0]    be_wide;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_data;
  logic [3:0]    req_be;
  logic          set_ovf, set_fovf;

  rxr_rdptr #(.RING_BASE(RING_BASE), .PW(PW)) u_rdptr (
    .clk(clk), .rst(rst), .size_idx(cfg_size_idx),
    .rd_we(rdptr_we), .rd_wdata(rdptr_wdata), .wr_ptr(wr_ptr),
    .size_mask(size_mask), .free_bytes(free_bytes), .empty(rx_empty));

  assign lane   = cnt[1:0];
  assign cnt_n  = {1'b0, cnt} + 17'd1;
  assign need_n = NW'(HDR_BYTES) + ((NW'(cnt_n) + NW'(3)) & ~NW'(3));
  assign ovf_n  = drop || (need_n >= NW'(free_bytes));
  assign take   = in_valid && !hdr_pend && !lost;
  assign be_wide = (5'd1 << (3'(lane) + 3'd1)) - 5'd1;
  assign data_off = (wr_ptr + PW'(HDR_BYTES) + {cnt[PW-1:2], 2'b00}) & size_mask;

  generate
    for (genvar l = 0; l < 4; l++) begin : g_lane
      assign word_n[8*l +: 8] = (lane == 2'(l)) ? in_data : acc[8*l +: 8];
    end
  endgenerate

  always_comb begin
    req      = 1'b0;
    req_addr = data_off[PW-1:2];
    req_data = word_n;
    req_be   = be_wide[3:0];
    if (hdr_pend) begin
      req      = 1'b1;
      req_addr = wr_ptr[PW-1:2];
      req_data = hdr_q;
      req_be   = 4'hF;
    end else if (take && (lane == 2'd3 || in_last) && !ovf_n) begin
      req = 1'b1;
    end
  end

  assign set_ovf  = take && in_last && ovf_n;
  assign set_fovf = hdr_pend && in_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      acc      <= '0;
      drop     <= 1'b0;
      lost     <= 1'b0;
      hdr_pend <= 1'b0;
      hdr_q    <= '0;
      need_q   <= '0;
      wr_ptr   <= '0;
    end else begin
      hdr_pend <= 1'b0;
      if (hdr_pend) begin
        wr_ptr <= (wr_ptr + need_q) & size_mask;
        if (in_valid && !in_last) lost <= 1'b1;
      end else if (in_valid) begin
        if (lost) begin
          if (in_last) lost <= 1'b0;
        end else begin
          acc <= word_n;
          if (in_last) begin
            cnt  <= '0;
            drop <= 1'b0;
            if (!ovf_n) begin
              hdr_pend     <= 1'b1;
              hdr_q.count  <= cnt_n[15:0];
              hdr_q.status <= in_status;
              need_q       <= need_n[PW-1:0];
            end
          end else begin
            cnt  <= cnt_n[15:0];
            drop <= ovf_n;
          end
        end
      end
    end
  end

  rxr_wport #(.AW(AW)) u_wport (
    .clk(clk), .rst(rst), .req(req), .addr(req_addr), .data(req_data), .be(req_be),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be));

  rxr_status #(.MISS_W(MISS_W)) u_status (
    .clk(clk), .rst(rst), .set_ok(hdr_pend), .set_ovf(set_ovf), .set_fovf(set_fovf),
    .clr_we(isr_clr_we), .clr_data(isr_clr_data),
    .status(irq_status), .missed(missed_count));

  AST_HDR_WRITE: assert property (@(posedge clk) disable iff (rst)
    hdr_pend |=> (mem_we && mem_be == 4'hF)); // R2
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !hdr_pend |=> $stable(wr_ptr)); // R5
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    hdr_pend |-> ((PW+1)'(need_q) < free_bytes)); // R9
endmodule

// File: tb/sim_rxring_writer.sv
module sim_rxring_writer;
  localparam int BASE = 64;

  logic clk = 0, rst = 1;
  logic [1:0] cfg_size_idx = 0;
  logic in_valid = 0, in_last = 0;
  logic [7:0] in_data = 0;
  logic [15:0] in_status = 0;
  logic rdptr_we = 0, isr_clr_we = 0;
  logic [15:0] rdptr_wdata = 0, isr_clr_data = 0;
  logic [15:0] irq_status;
  logic rx_empty;
  logic [7:0] missed_count;
  logic mem_we;
  logic [5:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0] mem_be;

  rxring_writer #(.RING_BASE(BASE), .MISS_W(8)) u0 (.*);

  always #2 clk = ~clk;

  logic [7:0] mem_b [0:255];
  always @(negedge clk)
    if (mem_we)
      for (int l = 0; l < 4; l++)
        if (mem_be[l]) mem_b[mem_addr*4 + l] = mem_wdata[8*l +: 8];

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;
  int size, exp_wr, exp_rd, exp_miss;
  int good_at, good_len, good_id, good_st;
  bit have_good;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int pat(int id, int k);
    return (id * 37 + k * 11 + 5) & 255;
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_last = 0; rdptr_we = 0; isr_clr_we = 0;
    end
  endtask

  task automatic send(int len, int id, int st);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1; in_data = 8'(pat(id, k));
      in_last = (k == len - 1); in_status = 16'(st);
    end
  endtask

  function automatic int frame_bad(int at, int len, int id, int st);
    int bad = 0;
    if (mem_b[at % size] != 8'(st)) bad++;
    if (mem_b[(at + 1) % size] != 8'(st >> 8)) bad++;
    if (mem_b[(at + 2) % size] != 8'(len)) bad++;
    if (mem_b[(at + 3) % size] != 8'(len >> 8)) bad++;
    for (int k = 0; k < len; k++)
      if (mem_b[(at + 4 + k) % size] != 8'(pat(id, k))) bad++;
    return bad;
  endfunction

  task automatic clear_all();
    @(negedge clk); isr_clr_we = 1; isr_clr_data = 16'hFFFF;
    idle(2);
    chk(irq_status == 0, "R8 clear", irq_status, 0);
  endtask

  task automatic consume();
    @(negedge clk); rdptr_we = 1; rdptr_wdata = 16'((exp_wr - 16) & 16'hFFFF);
    exp_rd = exp_wr;
    idle(3);
    chk(rx_empty == 1, "R6 R7 empty after consume", rx_empty, 1);
  endtask

  task automatic evaluate(int len, int id, int st);
    int fr, need, bad;
    fr = (exp_rd - exp_wr + size) % size;
    if (fr == 0) fr = size;
    need = 4 + ((len + 3) / 4) * 4;
    if (need < fr) begin
      bad = frame_bad(exp_wr, len, id, st);
      chk(bad == 0, (exp_wr + need > size) ? "R2 R3 R4 wrapped frame" : "R2 R3 frame", bad, 0);
      chk(irq_status[0] == 1 && irq_status[4] == 0, "R8 ok bit", irq_status, 1);
      chk(missed_count == 8'(exp_miss), "R9 no miss", missed_count, exp_miss);
      good_at = exp_wr; good_len = len; good_id = id; good_st = st; have_good = 1;
      exp_wr = (exp_wr + need) % size;
    end else begin
      exp_miss++;
      chk(irq_status[4] == 1 && irq_status[0] == 0, "R9 overflow bit", irq_status, 16);
      chk(missed_count == 8'(exp_miss), "R9 missed count", missed_count, exp_miss);
      if (have_good) begin
        bad = frame_bad(good_at, good_len, good_id, good_st);
        chk(bad == 0, "R9 unread frame intact", bad, 0);
      end
    end
    chk(rx_empty == (exp_rd == exp_wr), "R5 R7 empty flag", rx_empty, exp_rd == exp_wr);
    clear_all();
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem_b[a] = 0;
    for (int idx = 0; idx < 4; idx++) begin
      rst = 1; cfg_size_idx = 2'(idx);
      idle(3);
      rst = 0;
      size = BASE << ((idx == 3) ? 2 : idx);
      exp_wr = 0; exp_rd = 0; exp_miss = 0; have_good = 0;
      @(negedge clk);
      chk(irq_status == 0 && missed_count == 0 && mem_we == 0, "R11 reset outputs", irq_status, 0);
      chk(rx_empty == 1, "R11 R7 empty at reset", rx_empty, 1);
      for (int id = 0; id < 24; id++) begin
        int len, st;
        len = 1 + (id * 13) % 45;
        st = 1 | ((id & 7) << 13) | ((id & 3) << 1);
        send(len, id, st);
        idle(4);
        evaluate(len, id, st); // R1: size drives wrap and overflow points
        if (id % 3 == 2) consume();
      end
      // R10: back-to-back frames, second starts in the header cycle
      consume();
      send(8, 100, 16'h4001);
      send(6, 101, 16'h8001);
      idle(4);
      chk(irq_status[6] == 1, "R10 overrun bit", irq_status, 64);
      exp_miss++;
      evaluate(8, 100, 16'h4001);
      send(5, 102, 16'h2001);
      idle(4);
      evaluate(5, 102, 16'h2001);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule